// File: doc/BRIEF.md
# Multi-Standard Loss-of-Signal Detector

This block watches the sliced receive stream of one T1/E1 channel and raises a loss-of-signal flag when the line goes quiet. A strobe marks each pulse period. One input bit tells whether a pulse above the amplitude threshold arrived in that period. A two-bit rule select picks one of three rule sets: T1, E1 with a short window, or E1 with a long window. Each rule set has its own count of zeros that raises the flag and its own evidence of activity that lowers it.

While the flag is up, the block switches the receive clock selector to the master clock, but only in clock/data recovery mode. It also drives both receive data outputs high unless a local or analog loopback is enabled. The rule select is captured during reset and on every cycle that the flag is down, so a rule set in use cannot change while an exit is being judged.

Top module: `los_monitor`

## Requirements
- R1: During and after synchronous reset, `los` is 1 and every internal count and history is cleared. The zero run therefore restarts at 0 and the short-window history holds only zeros.
- R2: On each period strobe, a period with no pulse extends the run of consecutive zeros by one, and a period with a pulse sets the run back to zero.
- R3: With rule T1 (`mode_sel` = 0) and `los` low, `los` rises on the strobe of the 176th consecutive zero period.
- R4: With rule E1 short (`mode_sel` = 1) and `los` low, `los` rises on the strobe of the 32nd consecutive zero period.
- R5: With rule E1 long (`mode_sel` = 2 or 3) and `los` low, `los` rises on the strobe of the 2049th consecutive zero period.
- R6: Under rule T1 while `los` is high, a measuring window opens on the first pulse period and spans 176 periods, that pulse included. On the last period of the window, `los` falls if the window held at least 23 pulses. Otherwise the window closes and waits for the next pulse.
- R7: Under rule E1 short while `los` is high, `los` falls on a strobe when the last 32 periods, the current one included, hold at least 4 pulses and contain no run of more than 15 zeros.
- R8: Under rule E1 long while `los` is high, a period counts as active when the zero run after it is below 4. `los` falls on the 33rd consecutive active period, and any inactive period restarts the count.
- R9: `mode_sel` is captured during reset and on every cycle in which `los` is low. It is ignored while `los` is high.
- R10: `clk_sel` (1 = master clock) is 1 exactly when `los` is high and `cdr_mode` is 1. With `cdr_mode` at 0 it stays 0.
- R11: While `los` is high and both `lb_local` and `lb_analog` are 0, `rx_pos_out` and `rx_neg_out` are 1. In every other case they follow `rx_pos_in` and `rx_neg_in`.
- R12: `rx_mark` has no effect on cycles where `pp_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pp_en | input | 1 | Pulse-period strobe |
| rx_mark | input | 1 | Pulse above threshold in this period |
| mode_sel | input | 2 | Rule select: 0 T1, 1 E1 short, 2/3 E1 long |
| cdr_mode | input | 1 | 1 = clock/data recovery, 0 = data-only recovery |
| lb_local | input | 1 | Local loopback enabled |
| lb_analog | input | 1 | Analog loopback enabled |
| rx_pos_in | input | 1 | Positive receive data |
| rx_neg_in | input | 1 | Negative receive data |
| los | output | 1 | Loss-of-signal flag |
| clk_sel | output | 1 | Receive clock mux select, 1 = master clock |
| rx_pos_out | output | 1 | Positive receive data after forcing |
| rx_neg_out | output | 1 | Negative receive data after forcing |

## Verification
The assertions check these properties on every cycle:
- The zero run steps up by one or returns to zero only on a strobe.
- `los` rises only on a strobe with no pulse, and falls only on a strobe.
- The rule in use stays fixed while `los` is high.
- The T1 window count and the E1-long activity count stay within bounds.

The exact thresholds can only be shown by the bench scenarios. These are the 176th, 32nd and 2049th zero, the 22-versus-23 pulse window, the 15-versus-16 zero run inside the sliding window, and the activity count restarted by a four-zero gap. The scenarios also show that a rule change made while `los` is high is ignored, and they cover the clock and data forcing outputs.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int E1S_WIN = 32;

    typedef enum logic [1:0] {
        RULE_T1       = 2'd0,
        RULE_E1_SHORT = 2'd1,
        RULE_E1_LONG  = 2'd2
    } los_rule_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rx_pair_t;

    function automatic los_rule_e decode_rule(input logic [1:0] sel);
        case (sel)
            2'd0:    return RULE_T1;
            2'd1:    return RULE_E1_SHORT;
            default: return RULE_E1_LONG;
        endcase
    endfunction

    function automatic int longest_zero_run(input logic [E1S_WIN-1:0] v);
        int run;
        int best;
        run  = 0;
        best = 0;
        for (int i = 0; i < E1S_WIN; i++) begin
            if (v[i]) begin
                run = 0;
            end else begin
                run = run + 1;
                if (run > best) best = run;
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          mark,
    output logic [CW-1:0] zero_next
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] zero_cnt;

    always_comb begin
        if (!strobe)               zero_next = zero_cnt;
        else if (mark)             zero_next = '0;
        else if (zero_cnt == CMAX) zero_next = CMAX;
        else                       zero_next = zero_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) zero_cnt <= '0;
        else     zero_cnt <= zero_next;
    end

    // R2: a pulse period returns the run to zero
    p_run_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && mark) |=> (zero_cnt == '0));

    // R2: a quiet period extends the run by one
    p_run_step_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !mark && zero_cnt != CMAX) |=> (zero_cnt == $past(zero_cnt) + 1'b1));

    // R12: no strobe, no change
    p_run_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!strobe) |=> $stable(zero_cnt));

endmodule

// File: rtl/los_exit_eval.sv
module los_exit_eval import los_pkg::*; #(
    parameter int T1_WIN      = 176,
    parameter int E1S_MAX_RUN = 15,
    parameter int E1L_ACT     = 33,
    parameter int GAP         = 4,
    parameter int CW          = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          mark,
    input  logic          los,
    input  los_rule_e     rule,
    input  logic [CW-1:0] zero_next,
    output logic          exit_hit
);
    localparam int WW           = $clog2(T1_WIN + 1);
    localparam int AW           = $clog2(E1L_ACT + 1);
    localparam int T1_MIN_ONES  = T1_WIN / 8 + 1;
    localparam int E1S_MIN_ONES = E1S_WIN / 8;
    localparam logic [WW-1:0] WIN_LAST = WW'(T1_WIN);
    localparam logic [WW-1:0] ONES_MIN = WW'(T1_MIN_ONES);
    localparam logic [AW-1:0] ACT_LAST = AW'(E1L_ACT);
    localparam logic [CW-1:0] GAP_V    = CW'(GAP);

    // sliding history for the short E1 rule
    logic [E1S_WIN-1:0] hist_q, hist_nx;
    assign hist_nx = {hist_q[E1S_WIN-2:0], mark};

    always_ff @(posedge clk) begin
        if (rst)         hist_q <= '0;
        else if (strobe) hist_q <= hist_nx;
    end

    logic e1s_hit;
    assign e1s_hit = los && (rule == RULE_E1_SHORT) && strobe
                     && ($countones(hist_nx) >= E1S_MIN_ONES)
                     && (longest_zero_run(hist_nx) <= E1S_MAX_RUN);

    // fixed window for the T1 rule
    logic          win_on;
    logic [WW-1:0] win_cnt, ones_cnt, win_cnt_nx, ones_nx;
    logic          t1_last, t1_hit;
    assign win_cnt_nx = win_cnt + 1'b1;
    assign ones_nx    = ones_cnt + WW'(mark);
    assign t1_last    = los && (rule == RULE_T1) && strobe && win_on && (win_cnt_nx == WIN_LAST);
    assign t1_hit     = t1_last && (ones_nx >= ONES_MIN);

    always_ff @(posedge clk) begin
        if (rst || !los || rule != RULE_T1) begin
            win_on   <= 1'b0;
            win_cnt  <= '0;
            ones_cnt <= '0;
        end else if (strobe) begin
            if (!win_on) begin
                if (mark) begin
                    win_on   <= 1'b1;
                    win_cnt  <= WW'(1);
                    ones_cnt <= WW'(1);
                end
            end else if (win_cnt_nx == WIN_LAST) begin
                win_on   <= 1'b0;
                win_cnt  <= '0;
                ones_cnt <= '0;
            end else begin
                win_cnt  <= win_cnt_nx;
                ones_cnt <= ones_nx;
            end
        end
    end

    // activity run for the long E1 rule
    logic [AW-1:0] act_cnt, act_nx;
    logic          active, e1l_hit;
    assign active  = (zero_next < GAP_V);
    assign act_nx  = (act_cnt == ACT_LAST) ? ACT_LAST : act_cnt + 1'b1;
    assign e1l_hit = los && (rule == RULE_E1_LONG) && strobe && active && (act_nx == ACT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !los)  act_cnt <= '0;
        else if (strobe)  act_cnt <= active ? act_nx : '0;
    end

    assign exit_hit = t1_hit || e1s_hit || e1l_hit;

    // R6: window never runs past its length
    p_win_bound_r6: assert property (@(posedge clk) disable iff (rst)
        win_cnt < WIN_LAST);

    // R8: activity count stays within its limit
    p_act_bound_r8: assert property (@(posedge clk) disable iff (rst)
        act_cnt <= ACT_LAST);

endmodule

// File: rtl/los_out_force.sv
module los_out_force import los_pkg::*; (
    input  logic     los,
    input  logic     cdr_mode,
    input  logic     lb_local,
    input  logic     lb_analog,
    input  rx_pair_t data_in,
    output rx_pair_t data_out,
    output logic     clk_sel
);
    localparam int LANES = $bits(rx_pair_t);

    logic             force_hi;
    logic [LANES-1:0] din_v, dout_v;

    assign force_hi = los && !(lb_local || lb_analog);
    assign clk_sel  = los && cdr_mode;
    assign din_v    = data_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout_v[g] = force_hi | din_v[g];
    end

    assign data_out = dout_v;

endmodule

// File: rtl/los_monitor.sv
module los_monitor import los_pkg::*; #(
    parameter int T1_DECL      = 176,
    parameter int T1_WIN       = 176,
    parameter int E1S_DECL     = 32,
    parameter int E1S_MAX_RUN  = 15,
    parameter int E1L_ABOVE    = 2048,
    parameter int E1L_ACT_OVER = 32,
    parameter int GAP          = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pp_en,
    input  logic       rx_mark,
    input  logic [1:0] mode_sel,
    input  logic       cdr_mode,
    input  logic       lb_local,
    input  logic       lb_analog,
    input  logic       rx_pos_in,
    input  logic       rx_neg_in,
    output logic       los,
    output logic       clk_sel,
    output logic       rx_pos_out,
    output logic       rx_neg_out
);
    localparam int E1L_DECL = E1L_ABOVE + 1;
    localparam int MAX_AB   = (T1_DECL > E1S_DECL) ? T1_DECL : E1S_DECL;
    localparam int ZMAX     = (MAX_AB > E1L_DECL) ? MAX_AB : E1L_DECL;
    localparam int CW       = $clog2(ZMAX + 1);
    localparam logic [CW-1:0] LIM_T1  = CW'(T1_DECL);
    localparam logic [CW-1:0] LIM_E1S = CW'(E1S_DECL);
    localparam logic [CW-1:0] LIM_E1L = CW'(E1L_DECL);

    logic [CW-1:0] zero_next;
    logic          exit_hit, declare_hit;
    logic [CW-1:0] limit;
    los_rule_e     rule_q;

    los_zero_run #(.CW(CW)) u_run (
        .clk       (clk),
        .rst       (rst),
        .strobe    (pp_en),
        .mark      (rx_mark),
        .zero_next (zero_next)
    );

    los_exit_eval #(
        .T1_WIN      (T1_WIN),
        .E1S_MAX_RUN (E1S_MAX_RUN),
        .E1L_ACT     (E1L_ACT_OVER + 1),
        .GAP         (GAP),
        .CW          (CW)
    ) u_exit (
        .clk       (clk),
        .rst       (rst),
        .strobe    (pp_en),
        .mark      (rx_mark),
        .los       (los),
        .rule      (rule_q),
        .zero_next (zero_next),
        .exit_hit  (exit_hit)
    );

    always_comb begin
        case (rule_q)
            RULE_T1:       limit = LIM_T1;
            RULE_E1_SHORT: limit = LIM_E1S;
            default:       limit = LIM_E1L;
        endcase
    end

    assign declare_hit = pp_en && !rx_mark && (zero_next >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            los    <= 1'b1;
            rule_q <= decode_rule(mode_sel);
        end else begin
            if (!los) rule_q <= decode_rule(mode_sel);
            if (!los && declare_hit)  los <= 1'b1;
            else if (los && exit_hit) los <= 1'b0;
        end
    end

    rx_pair_t din, dout;
    assign din = '{pos: rx_pos_in, neg: rx_neg_in};

    los_out_force u_out (
        .los       (los),
        .cdr_mode  (cdr_mode),
        .lb_local  (lb_local),
        .lb_analog (lb_analog),
        .data_in   (din),
        .data_out  (dout),
        .clk_sel   (clk_sel)
    );

    assign rx_pos_out = dout.pos;
    assign rx_neg_out = dout.neg;

    // R3 R4 R5: the flag only rises on a quiet strobed period
    p_rise_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(los) |-> $past(pp_en && !rx_mark));

    // R6 R7 R8: the flag only falls on a strobe
    p_fall_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> $past(pp_en));

    // R9: rule held while the flag is up
    p_rule_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (los && $past(los) && !$past(rst)) |-> $stable(rule_q));

endmodule

// File: tb/sim_los_monitor.sv
`timescale 1ns/1ps
module sim_los_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pp_en = 1'b0;
    logic       rx_mark = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       cdr_mode = 1'b1;
    logic       lb_local = 1'b0;
    logic       lb_analog = 1'b0;
    logic       rx_pos_in = 1'b0;
    logic       rx_neg_in = 1'b0;
    logic       los, clk_sel, rx_pos_out, rx_neg_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    los_monitor u0 (
        .clk(clk), .rst(rst), .pp_en(pp_en), .rx_mark(rx_mark),
        .mode_sel(mode_sel), .cdr_mode(cdr_mode), .lb_local(lb_local),
        .lb_analog(lb_analog), .rx_pos_in(rx_pos_in), .rx_neg_in(rx_neg_in),
        .los(los), .clk_sel(clk_sel), .rx_pos_out(rx_pos_out), .rx_neg_out(rx_neg_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst = 1'b1;
        mode_sel = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        pp_en = 1'b1;
        rx_mark = b;
        @(posedge clk);
        #1;
        pp_en = 1'b0;
        rx_mark = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic send_pat4(input int n);
        for (int i = 0; i < n; i++) send((i % 4) == 0);
    endtask

    task automatic t_reset;
        cdr_mode = 1'b1; rx_pos_in = 1'b0; rx_neg_in = 1'b0;
        do_reset(2'd0);
        check("R1 los after reset", los, 1'b1);
        check("R10 clk_sel after reset", clk_sel, 1'b1);
        check("R11 pos forced after reset", rx_pos_out, 1'b1);
        check("R11 neg forced after reset", rx_neg_out, 1'b1);
    endtask

    task automatic t_t1_exit;
        for (int i = 0; i < 176; i++) send((i % 8) == 0);
        check("R6 22 pulses keep los", los, 1'b1);
        send_zeros(3);
        check("R6 idle window keeps los", los, 1'b1);
        for (int i = 0; i < 176; i++) begin
            send((i % 7) == 0);
            if (i == 174) check("R6 before window end", los, 1'b1);
        end
        check("R6 dense window clears los", los, 1'b0);
    endtask

    task automatic t_t1_declare;
        send_zeros(100);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            pp_en = 1'b0;
            rx_mark = 1'b1;
        end
        @(negedge clk);
        rx_mark = 1'b0;
        send_zeros(75);
        check("R12 unstrobed pulses ignored", los, 1'b0);
        send(1'b0);
        check("R3 los on 176th zero", los, 1'b1);
        cdr_mode = 1'b1; #1;
        check("R10 master clock in recovery mode", clk_sel, 1'b1);
        cdr_mode = 1'b0; #1;
        check("R10 no swap in data-only mode", clk_sel, 1'b0);
        rx_pos_in = 1'b0; rx_neg_in = 1'b1;
        lb_local = 1'b1; #1;
        check("R11 local loopback pos", rx_pos_out, 1'b0);
        check("R11 local loopback neg", rx_neg_out, 1'b1);
        lb_local = 1'b0; lb_analog = 1'b1; #1;
        check("R11 analog loopback pos", rx_pos_out, 1'b0);
        lb_analog = 1'b0; #1;
        check("R11 forced pos", rx_pos_out, 1'b1);
        cdr_mode = 1'b1; rx_neg_in = 1'b0;
    endtask

    task automatic t_e1_short;
        do_reset(2'd1);
        send_zeros(15); send(1'b1); send_zeros(14); send(1'b1); send(1'b1);
        check("R7 three pulses keep los", los, 1'b1);
        send(1'b1);
        check("R7 four pulses clear los", los, 1'b0);
        check("R10 clk_sel low without los", clk_sel, 1'b0);
        rx_pos_in = 1'b0; rx_neg_in = 1'b1; #1;
        check("R11 pos follows input", rx_pos_out, 1'b0);
        check("R11 neg follows input", rx_neg_out, 1'b1);
        rx_neg_in = 1'b0;
        send_zeros(20); send(1'b1); send_zeros(31);
        check("R2 pulse restarted run", los, 1'b0);
        send(1'b0);
        check("R4 los on 32nd zero", los, 1'b1);
        send(1'b1); send_zeros(16); send(1'b1); send(1'b1); send(1'b1);
        for (int n = 21; n <= 33; n++) send(((n - 21) % 4) == 0);
        check("R7 run of 16 keeps los", los, 1'b1);
        send(1'b0);
        check("R7 run of 15 clears los", los, 1'b0);
    endtask

    task automatic t_e1_long;
        do_reset(2'd2);
        send_pat4(20);
        send(1'b1); send_zeros(4);
        check("R8 gap restarts count", los, 1'b1);
        send_pat4(32);
        check("R8 32 active keep los", los, 1'b1);
        send(1'b1);
        check("R8 33rd active clears los", los, 1'b0);
        send_zeros(2048);
        check("R5 no los at 2048 zeros", los, 1'b0);
        send(1'b0);
        check("R5 los on 2049th zero", los, 1'b1);
        mode_sel = 2'd0;
        send_pat4(32);
        check("R9 still los after 32", los, 1'b1);
        send(1'b1);
        check("R9 long rule kept during los", los, 1'b0);
        send_zeros(175);
        check("R9 no los at 175 zeros", los, 1'b0);
        send(1'b0);
        check("R9 new rule taken after clear", los, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_t1_exit();
        t_t1_declare();
        t_e1_short();
        t_e1_long();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule